// File: doc/BRIEF.md
# Indirect Register Window Bridge

This bridge lets a host reach a large internal register space through a two-word direct window. Window word 0 is a control word that holds a target address, a direction bit, a start bit, and two read-only flags: one that shows a transfer is in flight and one that records misuse. Window word 1 is a shared 32-bit data word. Setting the start bit launches exactly one transfer on an internal request/acknowledge bus. For a read, the returned value lands in the data word.

The host follows a fixed sequence. To write, it loads the data word, waits until the in-flight flag is clear, and then writes the control word with the direction bit set to 1 and the start bit set. To read, it waits until the flag is clear, writes the control word with the direction bit set to 0 and the start bit set, waits until the flag clears again, and then reads the data word.

On the internal side, `ib_req` rises and stays high, with address, direction and write data held steady, until the target returns `ib_ack`. The target may take one or more cycles. This req/ack pair is the only flow control in the design: the target applies back-pressure simply by delaying `ib_ack`. The host side has no stall. Host reads are combinational, and host writes take effect at the clock edge where they are sampled.

Top module: `ibr_bridge`

## Requirements
- R1: After reset, the control word reads 0, the data word reads 0, and `ib_req` is 0.
- R2: `host_sel`=0 selects the control word and `host_sel`=1 selects the data word. Control word layout: bits [15:0] address, bit 16 direction (1 = write, 0 = read), bit 17 start, bit 18 in-flight (read-only), bit 19 overrun (read-only, sticky). All other bits read 0. The address, the direction and the data word read back as written.
- R3: A control write made while idle with bit 17 set causes the in-flight flag and `ib_req` to read 1 in the next cycle. In that cycle `ib_addr` and `ib_we` carry the written address and direction. Bit 17 always reads back as 0.
- R4: While a transfer is pending, `ib_req`, `ib_addr`, `ib_we` and `ib_wdata` stay stable. The in-flight flag and `ib_req` fall in the cycle after `ib_ack` is sampled high, so a target latency of N cycles gives exactly N cycles of in-flight flag.
- R5: In a write transfer, `ib_we` is 1 and `ib_wdata` equals the data word. The target sees exactly one transfer per start.
- R6: In a read transfer, `ib_we` is 0. The data word takes the value of `ib_rdata` at the edge where the in-flight flag falls.
- R7: A control write made while idle with bit 17 clear updates the address and direction but starts no transfer.
- R8: Any host write made while a transfer is in flight is ignored, whether to the control word or the data word, and it sets the overrun flag.
- R9: The overrun flag stays set until a control write made while idle has bit 19 set. That write clears the flag.
- R10: A write transfer leaves the data word unchanged. An `ib_ack` that arrives while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe, one per cycle |
| host_sel | input | 1 | Window word select (0 = control, 1 = data) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Contents of the selected window word |
| ib_req | output | 1 | Internal transfer request, held until acknowledged |
| ib_we | output | 1 | Internal transfer direction (1 = write) |
| ib_addr | output | 16 | Internal register address |
| ib_wdata | output | 32 | Internal write data |
| ib_ack | input | 1 | Internal transfer acknowledge |
| ib_rdata | input | 32 | Internal read data, valid with `ib_ack` |

## Verification
A stuck or late in-flight flag shows up as a count of busy cycles that does not match the target latency, and it shows in the very next control-word read after the acknowledge. A target address or direction that drifts while a transfer is pending, or a lost host-side guard, makes the model target log a wrong address, wrong data or a second transfer. This is visible as soon as the transfer completes. A wrong capture edge or a wrong capture condition leaves the wrong value in the data word, which the host reads back immediately.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  // Control word bit positions; the host sequence depends on these.
  localparam int unsigned IBR_ADDR_LSB = 0;
  localparam int unsigned IBR_RW_BIT   = 16;
  localparam int unsigned IBR_GO_BIT   = 17;
  localparam int unsigned IBR_BUSY_BIT = 18;
  localparam int unsigned IBR_OVR_BIT  = 19;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_DATA = 1'b1
  } ibr_sel_e;
endpackage

// File: rtl/ibr_window_regs.sv
module ibr_window_regs
  import ibr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] rd_value,
  output logic              start,
  output logic [ADDR_W-1:0] addr_q,
  output logic              rw_q,
  output logic [DATA_W-1:0] data_q
);
  logic ovr_q;
  logic ctrl_wr, data_wr;
  logic [DATA_W-1:0] ctrl_view;

  assign ctrl_wr = host_wr && (host_sel == SEL_CTRL);
  assign data_wr = host_wr && (host_sel == SEL_DATA);
  assign start   = ctrl_wr && !busy && host_wdata[IBR_GO_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rw_q   <= 1'b0;
      data_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (host_wr && busy) begin
        ovr_q <= 1'b1;
      end else if (ctrl_wr && host_wdata[IBR_OVR_BIT]) begin
        ovr_q <= 1'b0;
      end
      if (ctrl_wr && !busy) begin
        addr_q <= host_wdata[IBR_ADDR_LSB +: ADDR_W];
        rw_q   <= host_wdata[IBR_RW_BIT];
      end
      if (data_wr && !busy) begin
        data_q <= host_wdata;
      end else if (done && !rw_q) begin
        data_q <= rd_value;
      end
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[IBR_ADDR_LSB +: ADDR_W] = addr_q;
    ctrl_view[IBR_RW_BIT]   = rw_q;
    ctrl_view[IBR_BUSY_BIT] = busy;
    ctrl_view[IBR_OVR_BIT]  = ovr_q;
  end

  assign host_rdata = (host_sel == SEL_DATA) ? data_q : ctrl_view;

  AST_OVR_ON_BUSY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && busy |=> ovr_q); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q && !(ctrl_wr && !busy && host_wdata[IBR_OVR_BIT]) |=> ovr_q); // R9
  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(addr_q) && $stable(rw_q)); // R4
  AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    done && !rw_q |=> data_q == $past(rd_value)); // R6
  AST_WRITE_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rw_q |=> $stable(data_q)); // R10
endmodule

// File: rtl/ibr_xfer.sv
module ibr_xfer (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack,
  output logic busy,
  output logic done
);
  logic busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
    end else if (ack) begin
      busy_q <= 1'b0;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && ack;

  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q); // R3
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !ack |=> busy_q); // R4
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && ack |=> !busy_q); // R4
  AST_IDLE_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && !start |=> !busy_q); // R10
endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              ib_req,
  output logic              ib_we,
  output logic [ADDR_W-1:0] ib_addr,
  output logic [DATA_W-1:0] ib_wdata,
  input  logic              ib_ack,
  input  logic [DATA_W-1:0] ib_rdata
);
  logic start, busy, done, rw_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  ibr_window_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy), .done(done), .rd_value(ib_rdata),
    .start(start), .addr_q(addr_q), .rw_q(rw_q), .data_q(data_q)
  );

  ibr_xfer u_xfer (
    .clk(clk), .rst_n(rst_n),
    .start(start), .ack(ib_ack),
    .busy(busy), .done(done)
  );

  assign ib_req   = busy;
  assign ib_we    = rw_q;
  assign ib_addr  = addr_q;
  assign ib_wdata = data_q;

  AST_TARGET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ib_req && !ib_ack |=> $stable(ib_addr) && $stable(ib_we) && $stable(ib_wdata)); // R4
endmodule

// File: tb/ibr_bridge_test.sv
`timescale 1ns/1ps
module ibr_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_sel = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        ib_req, ib_we;
  logic [15:0] ib_addr;
  logic [31:0] ib_wdata;
  logic        ib_ack = 1'b0;
  logic [31:0] ib_rdata = '0;

  int checks = 0;
  int errors = 0;
  int lat = 1;
  int cnt = 0;
  bit spur = 1'b0;
  int txn = 0;
  logic [15:0] log_addr;
  logic [31:0] log_data;
  logic        log_we;

  localparam logic [31:0] RW  = 32'h0001_0000;
  localparam logic [31:0] GO  = 32'h0002_0000;
  localparam logic [31:0] BSY = 32'h0004_0000;
  localparam logic [31:0] OVR = 32'h0008_0000;

  always #2 clk = ~clk;

  ibr_bridge uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ib_req(ib_req), .ib_we(ib_we), .ib_addr(ib_addr), .ib_wdata(ib_wdata),
    .ib_ack(ib_ack), .ib_rdata(ib_rdata)
  );

  function automatic logic [31:0] tgt_val(input logic [15:0] a);
    return {a ^ 16'h5A5A, a};
  endfunction

  // Model target: acknowledges after lat cycles
  always @(negedge clk) begin
    if (ib_req) begin
      if (cnt + 1 >= lat) begin
        ib_ack   <= 1'b1;
        ib_rdata <= tgt_val(ib_addr);
        txn      <= txn + 1;
        log_addr <= ib_addr;
        log_data <= ib_wdata;
        log_we   <= ib_we;
      end else begin
        ib_ack <= 1'b0;
      end
      cnt <= cnt + 1;
    end else begin
      ib_ack   <= spur;
      ib_rdata <= spur ? 32'hBAD0_BAD0 : 32'h0;
      cnt      <= 0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic sel, output logic [31:0] d);
    host_sel = sel;
    #0.1;
    d = host_rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] c;
    n = 0;
    host_read(1'b0, c);
    while (c[18]) begin
      n++;
      @(negedge clk);
      host_read(1'b0, c);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    host_read(1'b0, v); check("R1 ctrl", v, 32'h0);
    host_read(1'b1, v); check("R1 data", v, 32'h0);
    check("R1 req", {31'b0, ib_req}, 32'h0);
  endtask

  task automatic t_layout();
    logic [31:0] v;
    int t0;
    t0 = txn;
    host_write(1'b0, RW | 32'h0000_1234);
    host_read(1'b0, v); check("R2 ctrl readback", v, RW | 32'h1234);
    check("R7 no req", {31'b0, ib_req}, 32'h0);
    host_write(1'b0, 32'hFFF0_4321);
    host_read(1'b0, v); check("R2 upper bits zero", v, 32'h0000_4321);
    host_write(1'b1, 32'hDEAD_BEEF);
    host_read(1'b1, v); check("R2 data readback", v, 32'hDEAD_BEEF);
    repeat (3) @(negedge clk);
    check("R7 no transfer", txn - t0, 0);
  endtask

  task automatic t_write(input int l, input logic [15:0] a, input logic [31:0] d);
    logic [31:0] v;
    int n, t0;
    lat = l; t0 = txn;
    host_write(1'b1, d);
    host_write(1'b0, GO | RW | a);
    host_read(1'b0, v); check("R3 busy+start clear", v, BSY | RW | a);
    check("R3 req", {31'b0, ib_req}, 32'h1);
    check("R3 addr", {16'h0, ib_addr}, {16'h0, a});
    check("R5 we", {31'b0, ib_we}, 32'h1);
    check("R5 wdata", ib_wdata, d);
    wait_idle(n);
    check("R4 busy cycles", n, l);
    check("R5 one txn", txn - t0, 1);
    check("R5 target addr", {16'h0, log_addr}, {16'h0, a});
    check("R5 target data", log_data, d);
    host_read(1'b1, v); check("R10 data kept", v, d);
  endtask

  task automatic t_read(input int l, input logic [15:0] a);
    logic [31:0] v;
    int n;
    lat = l;
    host_write(1'b0, GO | a);
    check("R6 we low", {31'b0, ib_we}, 32'h0);
    wait_idle(n);
    check("R4 read busy cycles", n, l);
    check("R6 target saw read", {31'b0, log_we}, 32'h0);
    host_read(1'b1, v); check("R6 read data", v, tgt_val(a));
  endtask

  task automatic t_overrun();
    logic [31:0] v;
    int n, t0;
    lat = 6; t0 = txn;
    host_write(1'b0, GO | 16'h0321);
    host_write(1'b0, GO | RW | 16'h7777);
    host_write(1'b1, 32'h1111_2222);
    host_read(1'b0, v); check("R8 overrun set", v, OVR | BSY | 32'h0321);
    wait_idle(n);
    host_read(1'b0, v); check("R8 ctrl ignored", v, OVR | 32'h0321);
    host_read(1'b1, v); check("R8 data ignored", v, tgt_val(16'h0321));
    repeat (3) @(negedge clk);
    check("R8 single txn", txn - t0, 1);
    host_write(1'b1, 32'h0);
    host_read(1'b0, v); check("R9 sticky", v, OVR | 32'h0321);
    host_write(1'b0, OVR | 32'h0055);
    host_read(1'b0, v); check("R9 cleared", v, 32'h0055);
  endtask

  task automatic t_spurious();
    logic [31:0] v;
    host_write(1'b1, 32'hCAFE_F00D);
    spur = 1'b1;
    repeat (4) @(negedge clk);
    spur = 1'b0;
    @(negedge clk);
    host_read(1'b1, v); check("R10 idle ack ignored", v, 32'hCAFE_F00D);
    host_read(1'b0, v); check("R10 still idle", v & BSY, 32'h0);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_write(3, 16'h00AB, 32'h1234_5678);
    t_write(1, 16'hFFFF, 32'h8000_0001);
    t_read(1, 16'h0F0F);
    t_read(5, 16'hA001);
    t_overrun();
    t_spurious();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule